// File: doc/BRIEF.md
# Round-Robin Multi-Slot Dynamic Delay

This block delays a stream of 24-bit words by a per-word amount and puts them back out on one serial output. A word is offered by raising the word strobe while holding the word on the data input. Bits [15:8] of the word give how many rising edges of the line strobe must pass before the word is sent out again. Because each word picks its own delay, a word may leave before an earlier one.

Eight independent delay slots take new words in strict turn, so up to eight words can be in flight at once. When a slot's count is reached, it asks to release its word. A fixed-priority merge sends one word per cycle as a one-cycle valid pulse. A word offered to a slot that is still busy is dropped, and a sticky error bit records the loss.

Top module: `dyn_delay_rr`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the cycle after it falls, `out_valid` is 0, `out_data` is 0 and `overflow` is 0. Reset makes slot 0 the next slot to receive a word and puts all slots in idle.
- R2: A new word is detected when `word_flag` is seen high in one registered sample and low in the sample before it. The word on `word_data` is captured at the second clock edge after `word_flag` is first sampled high. `word_data` must stay stable over that interval.
- R3: Captured words go to slots 0, 1, …, 7 in strict turn and then wrap to slot 0, with no unused pointer state.
- R4: After capture, a slot counts the rising edges of `line_strobe`, detected through a two-register sampler. Only edges whose detection pulse comes after the capture edge are counted. When the count equals the delay field `word_data[15:8]`, the slot becomes ready to release.
- R5: A delay field of 0 acts as a delay of 1: the word is ready after the first counted line-strobe edge.
- R6: A released word shows up as `out_valid` high for one cycle, with `out_data` equal to the captured word. When `out_valid` is 0, `out_data` is 0.
- R7: If a word arrives while the slot under the pointer is not idle, the word is dropped and `overflow` goes to 1 and stays there until reset. The busy slot keeps its word and timing, and the pointer still moves on to the next slot.
- R8: If several slots are ready in the same cycle, the lowest-numbered one is released first. Each of the others waits, keeping its word, and is released in a later cycle, one per cycle.
- R9: Every released word leaves on the single merged output in the cycle after its grant, and words that have been released are never lost or mixed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_flag | input | 1 | Word strobe; a rising edge offers the word on `word_data` |
| word_data | input | 24 | Word to delay; bits [15:8] hold the delay count |
| line_strobe | input | 1 | Time base; each rising edge advances the active slot counters |
| out_data | output | 24 | Merged released word, 0 when no word is released |
| out_valid | output | 1 | One-cycle pulse for each released word |
| overflow | output | 1 | Sticky flag: a word was dropped because its slot was busy |

## Verification
The assertions assume that the word strobe and the line strobe are each held high and then low for at least two clock cycles, so the two-register samplers see every edge. They also assume `word_data` does not change between a strobe rise and its capture. The bench drives both strobes as two-cycle-high, two-cycle-low pulses, and changes the data only together with a new strobe rise. A behavioural model of the slots, written with plain integer arrays, predicts the output in every cycle. Stimulus covers reuse of slots after wrap-around, zero delays, several slots becoming ready in the same cycle, and a ninth word that hits a busy slot.

// File: rtl/dd_pkg.sv
package dd_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_COUNT = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/dd_edge.sv
module dd_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic s0;
        logic s1;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s0 = din;
        st_d.s1 = st_q.s0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = st_q.s0 & ~st_q.s1;

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/dd_dispatch.sv
module dd_dispatch #(
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             new_word,
    input  logic [SLOTS-1:0] busy,
    output logic [SLOTS-1:0] load,
    output logic             overflow
);
    localparam logic [SLOTS-1:0] FIRST_SEL = SLOTS'(1);

    typedef struct packed {
        logic [SLOTS-1:0] sel;
        logic             ovf;
    } disp_t;

    disp_t st_d, st_q;
    logic  hit_busy;

    always_comb begin
        st_d     = st_q;
        hit_busy = |(st_q.sel & busy);
        load     = new_word ? (st_q.sel & ~busy) : '0;
        if (new_word) begin
            st_d.sel = {st_q.sel[SLOTS-2:0], st_q.sel[SLOTS-1]};
            if (hit_busy) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sel <= FIRST_SEL;
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign overflow = st_q.ovf;

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(st_q.sel));
    // R3
    load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load));
    // R7
    no_overflow_clear_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    // R7
    busy_not_loaded_chk: assert property (@(posedge clk) disable iff (rst)
        (load & busy) == '0);
endmodule

// File: rtl/dd_slot.sv
module dd_slot
    import dd_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int DLY_LSB = 8,
    parameter int DLY_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] word_in,
    input  logic              lrise,
    input  logic              grant,
    output logic              busy,
    output logic              req,
    output logic [DATA_W-1:0] word_out
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    typedef struct packed {
        slot_state_e       state;
        logic [DLY_W-1:0]  cnt;
        logic [DLY_W-1:0]  tgt;
        logic [DATA_W-1:0] word;
    } slot_t;

    slot_t            st_d, st_q;
    logic [DLY_W-1:0] dly_field;
    logic [DLY_W-1:0] cnt_inc;

    always_comb begin
        st_d      = st_q;
        dly_field = word_in[DLY_LSB +: DLY_W];
        cnt_inc   = st_q.cnt + ONE;
        unique case (st_q.state)
            SLOT_IDLE: begin
                st_d.cnt = '0;
                if (load) begin
                    st_d.state = SLOT_COUNT;
                    st_d.word  = word_in;
                    st_d.tgt   = (dly_field == '0) ? ONE : dly_field;
                end
            end
            SLOT_COUNT: begin
                if (lrise) begin
                    st_d.cnt = cnt_inc;
                    if (cnt_inc == st_q.tgt) st_d.state = SLOT_READY;
                end
            end
            SLOT_READY: begin
                if (grant) begin
                    st_d.state = SLOT_IDLE;
                    st_d.cnt   = '0;
                end
            end
            default: st_d.state = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.state <= SLOT_IDLE;
            st_q.cnt   <= '0;
            st_q.tgt   <= ONE;
            st_q.word  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.state != SLOT_IDLE);
    assign req      = (st_q.state == SLOT_READY);
    assign word_out = st_q.word;

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !grant) |=> (req && $stable(word_out)));
    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == SLOT_COUNT && !lrise) |=> $stable(st_q.cnt));
    // R7
    busy_word_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && load) |=> $stable(word_out));
    // R6
    grant_only_ready_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> req);
endmodule

// File: rtl/dd_merge.sv
module dd_merge #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SLOTS-1:0]        req,
    input  logic [SLOTS*DATA_W-1:0] words,
    output logic [SLOTS-1:0]        grant,
    output logic [DATA_W-1:0]       out_data,
    output logic                    out_valid
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t              st_d, st_q;
    logic [SLOTS-1:0]  lowest;
    logic [DATA_W-1:0] masked [SLOTS];
    logic [DATA_W-1:0] merged;

    assign lowest = req & (~req + SLOTS'(1));
    assign grant  = lowest;

    for (genvar i = 0; i < SLOTS; i++) begin : g_mask
        assign masked[i] = grant[i] ? words[i*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < SLOTS; i++) merged = merged | masked[i];
        st_d       = st_q;
        st_d.valid = |grant;
        st_d.data  = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_data  = st_q.data;
    assign out_valid = st_q.valid;

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));
    // R9
    req_served_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> out_valid);
endmodule

// File: rtl/dyn_delay_rr.sv
module dyn_delay_rr #(
    parameter int DATA_W  = 24,
    parameter int SLOTS   = 8,
    parameter int DLY_LSB = 8,
    parameter int DLY_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_flag,
    input  logic [DATA_W-1:0] word_data,
    input  logic              line_strobe,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              overflow
);
    localparam int BUS_W = SLOTS * DATA_W;

    logic              new_word;
    logic              lrise;
    logic [SLOTS-1:0]  load;
    logic [SLOTS-1:0]  busy;
    logic [SLOTS-1:0]  req;
    logic [SLOTS-1:0]  grant;
    logic [BUS_W-1:0]  words;

    dd_edge u_word_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (word_flag),
        .rise (new_word)
    );

    dd_edge u_line_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (line_strobe),
        .rise (lrise)
    );

    dd_dispatch #(.SLOTS(SLOTS)) u_dispatch (
        .clk      (clk),
        .rst      (rst),
        .new_word (new_word),
        .busy     (busy),
        .load     (load),
        .overflow (overflow)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        dd_slot #(
            .DATA_W  (DATA_W),
            .DLY_LSB (DLY_LSB),
            .DLY_W   (DLY_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (load[i]),
            .word_in  (word_data),
            .lrise    (lrise),
            .grant    (grant[i]),
            .busy     (busy[i]),
            .req      (req[i]),
            .word_out (words[i*DATA_W +: DATA_W])
        );
    end

    dd_merge #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .words     (words),
        .grant     (grant),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !overflow));
endmodule

// File: tb/dyn_delay_rr_tb.sv
`timescale 1ns/1ps
module dyn_delay_rr_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_flag = 1'b0;
    logic [23:0] word_data = '0;
    logic        line_strobe = 1'b0;
    logic [23:0] out_data;
    logic        out_valid;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    int run = 0;
    int max_run = 0;
    string tag = "R1";

    // behavioural reference
    int m_state [8];
    int m_cnt   [8];
    int m_tgt   [8];
    int m_word  [8];
    int m_ptr;
    bit m_ovf, m_valid;
    int m_data;
    bit mf0, mf1, ml0, ml1;

    always #5 clk = ~clk;

    dyn_delay_rr u_dut (
        .clk(clk), .rst(rst), .word_flag(word_flag), .word_data(word_data),
        .line_strobe(line_strobe), .out_data(out_data), .out_valid(out_valid),
        .overflow(overflow)
    );

    always @(posedge clk) begin
        bit newp, lr;
        int g;
        cyc++;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_state[i] = 0; m_cnt[i] = 0; m_tgt[i] = 1; m_word[i] = 0;
            end
            m_ptr = 0; m_ovf = 0; m_valid = 0; m_data = 0;
            mf0 = 0; mf1 = 0; ml0 = 0; ml1 = 0;
        end else begin
            newp = mf0 && !mf1;
            lr   = ml0 && !ml1;
            g = -1;
            for (int i = 7; i >= 0; i--) if (m_state[i] == 2) g = i;
            m_valid = (g >= 0);
            m_data  = (g >= 0) ? m_word[g] : 0;
            if (g >= 0) m_state[g] = 3; // granted marker
            for (int i = 0; i < 8; i++) begin
                if (m_state[i] == 1 && lr) begin
                    m_cnt[i]++;
                    if (m_cnt[i] == m_tgt[i]) m_state[i] = 2;
                end
            end
            if (newp) begin
                if (m_state[m_ptr] == 0) begin
                    m_state[m_ptr] = 1;
                    m_cnt[m_ptr]   = 0;
                    m_word[m_ptr]  = int'(word_data);
                    m_tgt[m_ptr]   = (word_data[15:8] == 0) ? 1 : int'(word_data[15:8]);
                end else begin
                    m_ovf = 1;
                end
                m_ptr = (m_ptr + 1) % 8;
            end
            if (g >= 0) begin m_state[g] = 0; m_cnt[g] = 0; end
            mf1 = mf0; mf0 = word_flag;
            ml1 = ml0; ml0 = line_strobe;
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 150000)", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (out_valid !== m_valid || out_data !== 24'(m_data)) begin
                errors++;
                $display("FAIL %s: cycle %0d valid/data actual %0b/%h expected %0b/%h",
                         tag, cyc, out_valid, out_data, m_valid, 24'(m_data));
            end
            checks++;
            if (overflow !== m_ovf) begin
                errors++;
                $display("FAIL %s: cycle %0d overflow actual %0b expected %0b",
                         tag, cyc, overflow, m_ovf);
            end
            if (out_valid) begin
                pulses++; run++;
                if (run > max_run) max_run = run;
            end else run = 0;
        end
    end

    task automatic check(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] w);
        @(negedge clk);
        word_data = w; word_flag = 1'b1;
        repeat (2) @(negedge clk);
        word_flag = 1'b0;
        repeat (1) @(negedge clk);
    endtask

    task automatic strobe(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); line_strobe = 1'b1;
            repeat (2) @(negedge clk); line_strobe = 1'b0;
            repeat (1) @(negedge clk);
        end
    endtask

    task automatic begin_phase(string t);
        tag = t; pulses = 0; max_run = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at outputs
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_data in reset", int'(out_data), 0);
        check("R1 overflow in reset", int'(overflow), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);

        // R2 / R4: one word, delay 3
        begin_phase("R4");
        send(24'hA5_03_5A);
        strobe(2);
        check("R4 not released before third edge", pulses, 0);
        strobe(3);
        check("R2 single word released once", pulses, 1);

        // R5: delay field zero
        begin_phase("R5");
        send(24'h3C_00_C3);
        strobe(2);
        check("R5 zero delay released once", pulses, 1);

        // R3 / R9: rotation and wrap with mixed delays
        begin_phase("R3");
        for (int i = 0; i < 10; i++) begin
            send({8'h40 + 8'(i), 8'(i % 3), 8'h90 + 8'(i)});
            strobe(1);
        end
        strobe(4);
        check("R3 ten words through wrapped slots", pulses, 10);
        check("R9 merged output saw no overflow", int'(overflow), 0);

        // R8: simultaneous readiness
        begin_phase("R8");
        for (int i = 0; i < 4; i++) send({8'hC0 + 8'(i), 8'd2, 8'h10 + 8'(i)});
        strobe(3);
        check("R8 four words released", pulses, 4);
        check("R8 back-to-back run length", max_run, 4);
        check("R6 no word left pending", int'(out_valid), 0);

        // R7: busy slot overflow
        begin_phase("R7");
        for (int i = 0; i < 9; i++) send({8'h70 + 8'(i), 8'd40, 8'h01 + 8'(i)});
        check("R7 overflow set on busy slot", int'(overflow), 1);
        strobe(42);
        check("R7 eight kept words released", pulses, 8);
        check("R7 overflow sticky", int'(overflow), 1);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule